// File: doc/BRIEF.md
# Banked 3D Colour LUT Loader

This block takes host register writes and fills the storage of a three-dimensional colour lookup table. The table is kept in two complete copies, A and B. While one copy feeds the pixel path, software loads the other, then switches the active copy by writing the mode last. Each copy is split into four sub-memories. The lattice points are spread over them, and the interpolator reads the four in parallel.

Software selects the copy to load, one sub-memory through a one-hot mask, and a channel precision. It then streams entries through one of two data registers. The packed register carries one full RGB entry of 10-bit channels per write. The dual register carries two consecutive entries of one channel per write, sent as red, then green, then blue. The block unpacks each write, keeps its own auto-incrementing index, and drops any write that does not fit. A dropped write raises a sticky error. A registered read port returns any stored entry to the pixel path.

Top module: `lut3d_loader`

## Requirements
- R1: After reset, the mode is bypass (0), the size bit is 0, the error flag is clear, and the write index, the channel phase and all control registers are 0.
- R2: The mode register at address 0 holds the mode in bits 1:0 and the size bit in bit 2. Mode 0 is bypass, 1 selects copy A and 2 selects copy B. A written value of 3 is stored as bypass. The size bit reads back as written and appears on `lut_small`.
- R3: The write-control register at address 1 holds the target copy in bit 0 (0 = A, 1 = B), the precision in bit 1 (1 = 10-bit channels, 0 = 12-bit channels) and the sub-memory mask in bits 7:4. Mask values 0x1, 0x2, 0x4 and 0x8 select sub-memories 0 to 3. Every write to this register returns the index and the channel phase to 0.
- R4: In 10-bit mode, a write to address 2 stores one entry: red from bits 29:20, green from bits 19:10 and blue from bits 9:0. Each channel is stored left-justified in 12 bits, with two zero LSBs. The index then advances by 1.
- R5: In 12-bit mode, each write to address 3 carries the first entry's channel in bits 15:4 and the second entry's channel in bits 31:20. Bits 3:0 and 19:16 are ignored. The writes come in red, green, blue order. The blue write stores both entries, at index and index+1, and advances the index by 2. Before the blue write, stored entries are unchanged.
- R6: For a lattice of N = L^3 points, with L = 17 at size 0 and L = 9 at size 1, sub-memory 0 holds N - 3*floor(N/4) entries and the others hold floor(N/4). That gives 1229/1228 entries at size 0 and 183/182 at size 1. When a pair's second entry lies past the limit, only the first entry is stored, and no error is raised.
- R7: Some data writes are dropped: those arriving at an index at or past the limit, those with a mask that is not one-hot, and those sent to the data register that does not match the precision. A dropped write leaves the index and the phase unchanged and sets a sticky error flag, which only reset clears.
- R8: A write changes only the selected copy and the selected sub-memory.
- R9: `rd_entry` returns {red[35:24], green[23:12], blue[11:0]} of the entry at (`rd_copy`, `rd_sub`, `rd_idx`) one clock after the address is presented.
- R10: The status register at address 4 reads the error flag in bit 0, the channel phase in bits 2:1 and the write index in bits 31:16. The error flag also drives `lut_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| lut_mode | output | 2 | Active mode: 0 bypass, 1 copy A, 2 copy B |
| lut_small | output | 1 | Lattice size bit: 0 is 17 points per axis, 1 is 9 |
| lut_err | output | 1 | Sticky dropped-write flag |
| rd_copy | input | 1 | Read copy select |
| rd_sub | input | 2 | Read sub-memory select |
| rd_idx | input | 16 | Read index inside the sub-memory |
| rd_entry | output | 36 | Registered read entry |

## Verification
Packed loads use random data in the two unused top bits to show those bits are ignored. Dual loads put random junk in the padding nibbles, which a wrong field slice would pick up. Sub-memories are filled exactly to their limit at both lattice sizes and then written once more, which separates the base capacity from the larger capacity of sub-memory 0. An odd-length pair load at the small size checks that the overhanging second entry is skipped quietly. Pending red and green values are overwritten on top of a stored pair, to show that nothing is stored before blue. A load into the other copy shows it leaves the first copy's contents intact.

// File: rtl/lut3d_loader.sv
module lut3d_loader #(
  parameter int LAT_BIG   = 17,
  parameter int LAT_SMALL = 9,
  parameter int CH_W      = 12,
  parameter int NARROW_W  = 10,
  parameter int IDX_W     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [1:0]          lut_mode,
  output logic                lut_small,
  output logic                lut_err,
  input  logic                rd_copy,
  input  logic [1:0]          rd_sub,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [3*CH_W-1:0]   rd_entry
);
  localparam int N_BIG   = LAT_BIG * LAT_BIG * LAT_BIG;
  localparam int N_SMALL = LAT_SMALL * LAT_SMALL * LAT_SMALL;
  localparam int CAP_B   = N_BIG / 4;
  localparam int CAP_B0  = N_BIG - 3 * CAP_B;
  localparam int CAP_S   = N_SMALL / 4;
  localparam int CAP_S0  = N_SMALL - 3 * CAP_S;
  localparam int DEPTH   = CAP_B0;
  localparam int AW      = $clog2(DEPTH);
  localparam int EW      = 3 * CH_W;
  localparam int PAD     = CH_W - NARROW_W;
  localparam int FW      = 16;

  localparam logic [IDX_W-1:0] CAP_B_I  = IDX_W'(CAP_B);
  localparam logic [IDX_W-1:0] CAP_B0_I = IDX_W'(CAP_B0);
  localparam logic [IDX_W-1:0] CAP_S_I  = IDX_W'(CAP_S);
  localparam logic [IDX_W-1:0] CAP_S0_I = IDX_W'(CAP_S0);
  localparam logic [IDX_W-1:0] DEPTH_I  = IDX_W'(DEPTH);

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_WCTL = 3'd1;
  localparam logic [2:0] A_D30  = 3'd2;
  localparam logic [2:0] A_D12  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  logic [1:0]       mode_q;
  logic             small_q, copy_q, ten_q, err_q;
  logic [3:0]       mask_q;
  logic [IDX_W-1:0] wr_idx;
  logic [1:0]       phase_q;
  logic [CH_W-1:0]  red_lo, red_hi, grn_lo, grn_hi;

  logic [1:0]       sub_sel;
  logic             mask_ok;
  logic [IDX_W-1:0] cap_cur;
  logic [IDX_W-1:0] idx_p1;
  logic             d30_hit, d12_hit, acc30, acc12, bad, commit;
  logic [CH_W-1:0]  lo_ch, hi_ch;
  logic [EW-1:0]    e30, wr0_data, wr1_data;
  logic             wr0_en, wr1_en;

  assign sub_sel = {mask_q[3] | mask_q[2], mask_q[3] | mask_q[1]};
  assign mask_ok = $onehot(mask_q);
  assign idx_p1  = wr_idx + IDX_W'(1);

  always_comb begin
    if (small_q) cap_cur = (sub_sel == 2'd0) ? CAP_S0_I : CAP_S_I;
    else         cap_cur = (sub_sel == 2'd0) ? CAP_B0_I : CAP_B_I;
  end

  assign d30_hit = reg_we && (reg_addr == A_D30);
  assign d12_hit = reg_we && (reg_addr == A_D12);
  assign acc30   = d30_hit &&  ten_q && mask_ok && (wr_idx < cap_cur);
  assign acc12   = d12_hit && !ten_q && mask_ok && (wr_idx < cap_cur);
  assign bad     = (d30_hit || d12_hit) && !(acc30 || acc12);
  assign commit  = acc12 && (phase_q == 2'd2);

  assign lo_ch = reg_wdata[FW-1 -: CH_W];
  assign hi_ch = reg_wdata[2*FW-1 -: CH_W];
  assign e30   = {reg_wdata[3*NARROW_W-1 -: NARROW_W], {PAD{1'b0}},
                  reg_wdata[2*NARROW_W-1 -: NARROW_W], {PAD{1'b0}},
                  reg_wdata[NARROW_W-1:0],             {PAD{1'b0}}};

  assign wr0_en   = acc30 || commit;
  assign wr0_data = acc30 ? e30 : {red_lo, grn_lo, lo_ch};
  assign wr1_en   = commit && (idx_p1 < cap_cur);
  assign wr1_data = {red_hi, grn_hi, hi_ch};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      small_q <= 1'b0;
      copy_q  <= 1'b0;
      ten_q   <= 1'b0;
      mask_q  <= '0;
      wr_idx  <= '0;
      phase_q <= '0;
      err_q   <= 1'b0;
      red_lo  <= '0;
      red_hi  <= '0;
      grn_lo  <= '0;
      grn_hi  <= '0;
    end else begin
      if (reg_we && reg_addr == A_MODE) begin
        mode_q  <= (reg_wdata[1:0] == 2'd3) ? 2'd0 : reg_wdata[1:0];
        small_q <= reg_wdata[2];
      end
      if (reg_we && reg_addr == A_WCTL) begin
        copy_q  <= reg_wdata[0];
        ten_q   <= reg_wdata[1];
        mask_q  <= reg_wdata[7:4];
        wr_idx  <= '0;
        phase_q <= '0;
      end
      if (acc30) wr_idx <= idx_p1;
      if (acc12) begin
        case (phase_q)
          2'd0: begin
            red_lo  <= lo_ch;
            red_hi  <= hi_ch;
            phase_q <= 2'd1;
          end
          2'd1: begin
            grn_lo  <= lo_ch;
            grn_hi  <= hi_ch;
            phase_q <= 2'd2;
          end
          default: begin
            phase_q <= 2'd0;
            wr_idx  <= wr_idx + IDX_W'(2);
          end
        endcase
      end
      if (bad) err_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = {29'd0, small_q, mode_q};
      A_WCTL:  reg_rdata = {24'd0, mask_q, 2'b00, ten_q, copy_q};
      A_STAT:  reg_rdata = {wr_idx, 13'd0, phase_q, err_q};
      default: reg_rdata = '0;
    endcase
  end

  assign lut_mode  = mode_q;
  assign lut_small = small_q;
  assign lut_err   = err_q;

  logic [EW-1:0] bank_q [8];
  logic [2:0]    rsel_q;
  logic          rd_ok;

  assign rd_ok = rd_idx < DEPTH_I;

  for (genvar c = 0; c < 2; c++) begin : g_copy
    for (genvar s = 0; s < 4; s++) begin : g_sub
      logic [EW-1:0] mem [DEPTH];
      logic [EW-1:0] q;
      logic          hit;
      assign hit = (copy_q == 1'(c)) && (sub_sel == 2'(s));
      always_ff @(posedge clk) begin
        if (wr0_en && hit) mem[wr_idx[AW-1:0]] <= wr0_data;
        if (wr1_en && hit) mem[idx_p1[AW-1:0]] <= wr1_data;
        q <= rd_ok ? mem[rd_idx[AW-1:0]] : '0;
      end
      assign bank_q[c*4+s] = q;
    end
  end

  always_ff @(posedge clk) rsel_q <= {rd_copy, rd_sub};
  assign rd_entry = bank_q[rsel_q];
endmodule

// File: rtl/lut3d_loader_chk.sv
module lut3d_loader_chk #(
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [1:0]       lut_mode,
  input logic             lut_err,
  input logic [IDX_W-1:0] wr_idx,
  input logic [1:0]       phase_q,
  input logic [IDX_W-1:0] cap_cur,
  input logic             ten_q,
  input logic [3:0]       mask_q
);
  // R2
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 3'd0 && reg_wdata[1:0] != 2'd3 |=> lut_mode == $past(reg_wdata[1:0]));

  // R3
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 3'd1 |=> wr_idx == '0 && phase_q == 2'd0);

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 3'd2 && ten_q && $onehot(mask_q) && wr_idx < cap_cur
    |=> wr_idx == $past(wr_idx) + IDX_W'(1));

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);

  // R7
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && (reg_addr == 3'd2 || reg_addr == 3'd3) && wr_idx >= cap_cur
    |=> wr_idx == $past(wr_idx) && lut_err);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lut_err |=> lut_err);
endmodule

bind lut3d_loader lut3d_loader_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .lut_mode(lut_mode), .lut_err(lut_err),
  .wr_idx(wr_idx), .phase_q(phase_q), .cap_cur(cap_cur),
  .ten_q(ten_q), .mask_q(mask_q)
);

// File: tb/sim_lut3d_loader.sv
`timescale 1ns/1ps
module sim_lut3d_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  lut_mode;
  logic        lut_small, lut_err;
  logic        rd_copy = 1'b0;
  logic [1:0]  rd_sub = '0;
  logic [15:0] rd_idx = '0;
  logic [35:0] rd_entry;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lut3d_loader u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lut_mode(lut_mode),
    .lut_small(lut_small), .lut_err(lut_err), .rd_copy(rd_copy),
    .rd_sub(rd_sub), .rd_idx(rd_idx), .rd_entry(rd_entry)
  );

  function automatic logic [9:0] v10(int salt, int i, int ch);
    return 10'((i * 37 + ch * 211 + salt * 13) & 1023);
  endfunction
  function automatic logic [11:0] v12(int salt, int i, int ch);
    return 12'((i * 53 + ch * 997 + salt * 17) & 4095);
  endfunction
  function automatic logic [35:0] e30(int salt, int i);
    return {v10(salt, i, 0), 2'b00, v10(salt, i, 1), 2'b00, v10(salt, i, 2), 2'b00};
  endfunction
  function automatic logic [35:0] e12(int salt, int i);
    return {v12(salt, i, 0), v12(salt, i, 1), v12(salt, i, 2)};
  endfunction

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    reg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic read_entry(logic c, logic [1:0] s, int i, output logic [35:0] v);
    @(negedge clk);
    rd_copy = c;
    rd_sub = s;
    rd_idx = 16'(i);
    @(negedge clk);
    v = rd_entry;
  endtask

  task automatic load30(int salt, int start, int count);
    for (int i = start; i < start + count; i++)
      wreg(3'd2, {2'($urandom), v10(salt, i, 0), v10(salt, i, 1), v10(salt, i, 2)});
  endtask

  task automatic w12(int salt, int i, int ch);
    wreg(3'd3, {v12(salt, i + 1, ch), 4'($urandom), v12(salt, i, ch), 4'($urandom)});
  endtask

  task automatic load12(int salt, int start, int pairs);
    for (int p = 0; p < pairs; p++)
      for (int ch = 0; ch < 3; ch++) w12(salt, start + 2 * p, ch);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [35:0] e;
    int s1, s2, s3, s4, s5, s6, s7;
    void'($urandom(32'h5eed_1234));
    s1 = $urandom_range(1, 999); s2 = $urandom_range(1, 999);
    s3 = $urandom_range(1, 999); s4 = $urandom_range(1, 999);
    s5 = $urandom_range(1, 999); s6 = $urandom_range(1, 999);
    s7 = $urandom_range(1, 999);

    do_reset();
    // R1 reset state
    chk("R1 mode", 36'(lut_mode), 36'd0);
    chk("R1 err", 36'(lut_err), 36'd0);
    rreg(3'd4, r); chk("R1 status", 36'(r), 36'd0);
    rreg(3'd1, r); chk("R1 wctrl", 36'(r), 36'd0);

    // R2 mode encodings
    wreg(3'd0, 32'd1); chk("R2 copy A", 36'(lut_mode), 36'd1);
    wreg(3'd0, 32'd2); chk("R2 copy B", 36'(lut_mode), 36'd2);
    wreg(3'd0, 32'd3); chk("R2 mode 3 as bypass", 36'(lut_mode), 36'd0);
    wreg(3'd0, 32'd4); rreg(3'd0, r);
    chk("R2 size readback", 36'(r), 36'd4);
    chk("R2 lut_small", 36'(lut_small), 36'd1);
    wreg(3'd0, 32'd0);

    // R4 packed load, copy A sub 0
    wreg(3'd1, 32'h12);
    rreg(3'd1, r); chk("R3 wctrl readback", 36'(r), 36'h12);
    load30(s1, 0, 40);
    rreg(3'd4, r); chk("R10 index after packed", 36'(r), 36'(32'd40 << 16));
    for (int k = 0; k < 8; k++) begin
      int i = $urandom_range(39);
      read_entry(1'b0, 2'd0, i, e); chk("R4 R9 packed entry", e, e30(s1, i));
    end

    // R3 index reset
    wreg(3'd1, 32'h12);
    rreg(3'd4, r); chk("R3 index cleared", 36'(r), 36'd0);

    // R5 dual load, copy B sub 2
    wreg(3'd1, 32'h41);
    load12(s2, 0, 10);
    rreg(3'd4, r); chk("R5 index after pairs", 36'(r), 36'(32'd20 << 16));
    for (int i = 0; i < 20; i++) begin
      read_entry(1'b1, 2'd2, i, e); chk("R5 dual entry", e, e12(s2, i));
    end

    // R8 copy B sub 0 leaves copy A sub 0 intact
    wreg(3'd1, 32'h11);
    load12(s3, 0, 5);
    for (int i = 0; i < 10; i++) begin
      read_entry(1'b0, 2'd0, i, e); chk("R8 copy A intact", e, e30(s1, i));
    end
    read_entry(1'b1, 2'd0, 9, e); chk("R8 copy B written", e, e12(s3, 9));

    // R5 nothing stored before blue
    wreg(3'd1, 32'h11);
    w12(s4, 0, 0); w12(s4, 0, 1);
    rreg(3'd4, r); chk("R10 phase after green", 36'(r), 36'd4);
    read_entry(1'b1, 2'd0, 0, e); chk("R5 pending not stored", e, e12(s3, 0));
    w12(s4, 0, 2);
    read_entry(1'b1, 2'd0, 0, e); chk("R5 blue commits first", e, e12(s4, 0));
    read_entry(1'b1, 2'd0, 1, e); chk("R5 blue commits second", e, e12(s4, 1));

    // R7 format mismatch
    wreg(3'd2, 32'h3fff_ffff);
    rreg(3'd4, r); chk("R7 mismatch dropped", 36'(r), 36'(32'h0002_0001));
    chk("R7 err out", 36'(lut_err), 36'd1);
    read_entry(1'b1, 2'd0, 2, e); chk("R7 mismatch no store", e, e12(s3, 2));
    load12(s3, 2, 1);
    chk("R7 err sticky", 36'(lut_err), 36'd1);

    // R7 no mask
    do_reset();
    wreg(3'd1, 32'h02);
    wreg(3'd2, 32'h1234_5678);
    rreg(3'd4, r); chk("R7 no mask", 36'(r), 36'd1);

    // R6 small lattice, sub 1 limit 182
    do_reset();
    wreg(3'd0, 32'd4);
    wreg(3'd1, 32'h22);
    load30(s5, 0, 182);
    rreg(3'd4, r); chk("R6 small sub1 full", 36'(r), 36'(32'd182 << 16));
    read_entry(1'b0, 2'd1, 181, e); chk("R6 last small entry", e, e30(s5, 181));
    wreg(3'd2, 32'h0);
    rreg(3'd4, r); chk("R7 past small limit", 36'(r), 36'(32'd182 << 16 | 32'd1));

    // R6 small lattice, sub 0 odd limit 183 with pairs
    do_reset();
    wreg(3'd0, 32'd4);
    wreg(3'd1, 32'h10);
    load12(s6, 0, 92);
    rreg(3'd4, r); chk("R6 odd pair no error", 36'(r), 36'(32'd184 << 16));
    read_entry(1'b0, 2'd0, 182, e); chk("R6 last odd entry", e, e12(s6, 182));
    w12(s6, 184, 0);
    chk("R7 past odd limit", 36'(lut_err), 36'd1);

    // R6 big lattice, sub 3 limit 1228
    do_reset();
    wreg(3'd1, 32'h83);
    load30(s7, 0, 1228);
    rreg(3'd4, r); chk("R6 big sub3 full", 36'(r), 36'(32'd1228 << 16));
    read_entry(1'b1, 2'd3, 1227, e); chk("R6 last big entry", e, e30(s7, 1227));
    wreg(3'd2, 32'h0);
    chk("R7 past big limit", 36'(lut_err), 36'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule